// File: doc/BRIEF.md
# Maskable Interrupt Acknowledge Sequencer

This block sits between an external maskable interrupt line and the execution core. The request line is level-sensitive and may change at any time relative to the core clock, so it first passes through a flop synchronizer. The synchronized request is accepted only when the core's interrupt-enable flag is set and the core signals an instruction boundary.

Once a request is accepted, the sequencer runs two separate interrupt-acknowledge bus cycles. Each cycle uses a simple request/done handshake with the bus unit, and the two cycles are split by one idle clock. When the second cycle completes, the sequencer captures an 8-bit vector from the low byte of the data bus and hands it to the core, together with a one-clock valid strobe. After acceptance the sequence always runs to the end, even if the request line falls.

Top module: `irq_ack_seq`

## Requirements
- R1: In the cycle after synchronous reset is released, `bus_req`, `ack_second`, `busy`, `vector_valid` and `vector` are all 0.
- R2: Suppose `irq_req` is raised just before a clock edge while `irq_enable` and `insn_boundary` are both 1. Then `bus_req` rises with `ack_second`=0 after exactly three rising edges: two synchronizer stages and one state register.
- R3: While `irq_enable` is 0, a held request never raises `bus_req`, `busy` or `vector_valid`.
- R4: While `insn_boundary` is 0, a held request does not start a sequence. Once `insn_boundary` goes to 1 with the request still present, `bus_req` rises one clock later.
- R5: Each accepted request produces exactly two acknowledge bus cycles. The first has `ack_second`=0 and the second has `ack_second`=1. `bus_req` is 0 for exactly one clock between them and stays 0 once the second cycle is done.
- R6: On the clock after `bus_done` ends the second cycle, `vector` equals `bus_data[7:0]` as sampled at that completion. The data present when the first cycle completes has no effect on `vector`.
- R7: `vector_valid` is 1 for exactly one clock per completed sequence.
- R8: Dropping `irq_req` after the first cycle has started does not stop the sequence. Both cycles still run and the vector is still delivered.
- R9: `bus_req` stays 1 during an acknowledge cycle until `bus_done` is seen, however many clocks that takes.
- R10: Asserting `rst` in the middle of a sequence returns the block to idle. `bus_req`, `busy` and `vector_valid` read 0 on the next clock, and no vector is delivered afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 1 | Asynchronous level-sensitive maskable interrupt request |
| irq_enable | input | 1 | Core interrupt-enable flag |
| insn_boundary | input | 1 | High when the core is at an instruction boundary |
| bus_done | input | 1 | One-clock pulse from the bus unit ending the current acknowledge cycle |
| bus_data | input | DATA_W (32) | Data bus; the low VEC_W bits carry the vector |
| bus_req | output | 1 | Requests an acknowledge bus cycle; held until bus_done |
| ack_second | output | 1 | 0 during the first acknowledge cycle, 1 during the second |
| busy | output | 1 | A sequence is in progress |
| vector | output | VEC_W (8) | Captured interrupt vector |
| vector_valid | output | 1 | One-clock strobe marking a fresh vector |

## Verification
The hardest situations to reach are the ones where the inputs change while a sequence is running. Examples are the request being withdrawn after acceptance, the bus unit stalling for many clocks, and a reset arriving between the two acknowledge cycles. The stimulus table plays the part of the bus unit. It controls the stall length of each cycle and the data it returns, and it places a decoy low byte on the first completion. A separate flag drops the request as soon as `bus_req` appears. Directed tests then reset in the idle gap and hold the boundary strobe low until the request has fully passed through the synchronizer.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACK1 = 2'd1,
        ST_GAP  = 2'd2,
        ST_ACK2 = 2'd3
    } ack_state_e;

    typedef struct packed {
        logic req;
        logic second;
    } bus_ctl_t;

    function automatic bus_ctl_t ctl_for(ack_state_e s);
        bus_ctl_t c;
        c.req    = (s == ST_ACK1) || (s == ST_ACK2);
        c.second = (s == ST_ACK2);
        return c;
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/irq_accept_gate.sv
module irq_accept_gate (
    input  logic req_sync,
    input  logic ie,
    input  logic boundary,
    input  logic idle,
    output logic accept
);
    assign accept = req_sync & ie & boundary & idle;
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_ack_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  logic       bus_done,
    output ack_state_e state,
    output bus_ctl_t   ctl,
    output logic       capture
);
    ack_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept)   nxt = ST_ACK1;
            ST_ACK1: if (bus_done) nxt = ST_GAP;
            ST_GAP:                nxt = ST_ACK2;
            ST_ACK2: if (bus_done) nxt = ST_IDLE;
            default:               nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    assign ctl     = ctl_for(state);
    assign capture = (state == ST_ACK2) && bus_done;

    assert_bus_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (ctl.req && !bus_done) |=> ctl.req);
    assert_gap_between_cycles_R5: assert property (@(posedge clk) disable iff (rst)
        (ctl.req && !ctl.second && bus_done) |=> !ctl.req);
    assert_second_follows_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_GAP) |=> (ctl.req && ctl.second));
endmodule

// File: rtl/irq_vector_latch.sv
module irq_vector_latch #(
    parameter int DATA_W = 32,
    parameter int VEC_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] data,
    output logic [VEC_W-1:0]  vector,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vector <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= capture;
            if (capture) vector <= data[VEC_W-1:0];
        end
    end

    assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    assert_vector_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(vector));
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
    import irq_ack_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 32,
    parameter int VEC_W       = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              irq_req,
    input  logic              irq_enable,
    input  logic              insn_boundary,
    input  logic              bus_done,
    input  logic [DATA_W-1:0] bus_data,
    output logic              bus_req,
    output logic              ack_second,
    output logic              busy,
    output logic [VEC_W-1:0]  vector,
    output logic              vector_valid
);
    logic       req_s;
    logic       accept;
    logic       capture;
    ack_state_e state;
    bus_ctl_t   ctl;

    irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(irq_req), .sync_out(req_s)
    );

    irq_accept_gate u_gate (
        .req_sync(req_s), .ie(irq_enable), .boundary(insn_boundary),
        .idle(state == ST_IDLE), .accept(accept)
    );

    irq_ack_fsm u_fsm (
        .clk(clk), .rst(rst), .accept(accept), .bus_done(bus_done),
        .state(state), .ctl(ctl), .capture(capture)
    );

    irq_vector_latch #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_vec (
        .clk(clk), .rst(rst), .capture(capture), .data(bus_data),
        .vector(vector), .valid(vector_valid)
    );

    assign bus_req    = ctl.req;
    assign ack_second = ctl.second;
    assign busy       = (state != ST_IDLE);

    assert_start_gated_R3: assert property (@(posedge clk) disable iff (rst)
        ($rose(busy)) |-> $past(irq_enable && insn_boundary));
    assert_valid_after_second_R6: assert property (@(posedge clk) disable iff (rst)
        vector_valid |-> $past(ack_second && bus_done));
endmodule

// File: tb/test_irq_ack_seq.sv
module test_irq_ack_seq;
    logic        clk = 1'b0;
    logic        rst;
    logic        irq_req, irq_enable, insn_boundary, bus_done;
    logic [31:0] bus_data;
    logic        bus_req, ack_second, busy, vector_valid;
    logic [7:0]  vector;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    irq_ack_seq i_irq_ack_seq (
        .clk(clk), .rst(rst), .irq_req(irq_req), .irq_enable(irq_enable),
        .insn_boundary(insn_boundary), .bus_done(bus_done), .bus_data(bus_data),
        .bus_req(bus_req), .ack_second(ack_second), .busy(busy),
        .vector(vector), .vector_valid(vector_valid)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // entry: {ie, boundary, withdraw, expect_start, stall[3:0], first_data, second_data}
    localparam logic [71:0] TBL [6] = '{
        {1'b1, 1'b1, 1'b0, 1'b1, 4'd0, 32'h0000_00AA, 32'h1234_5620},
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd2, 32'hFFFF_FF11, 32'h0000_0021},
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 32'h0,         32'h0},
        {1'b1, 1'b1, 1'b0, 1'b1, 4'd9, 32'h0000_0055, 32'hABCD_EFFF},
        {1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 32'h0,         32'h0},
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd5, 32'h0000_0000, 32'h0000_0000}
    };

    task automatic finish_cycle(input int stall, input logic [31:0] data);
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            check("R9 bus_req held while stalled", bus_req, 1);
        end
        bus_done = 1'b1;
        bus_data = data;
        @(negedge clk);
        bus_done = 1'b0;
        bus_data = 32'hDEAD_BEEF;
    endtask

    task automatic idle_wait(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check("R3/R5 no stray activity", {bus_req, busy, vector_valid}, 0);
        end
    endtask

    initial begin
        int cnt;
        irq_req = 0; irq_enable = 0; insn_boundary = 0; bus_done = 0; bus_data = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset outputs", {bus_req, ack_second, busy, vector_valid, vector}, 0);

        foreach (TBL[i]) begin
            logic       ie, bnd, wd, exp_start;
            logic [3:0] stall;
            logic [31:0] d1, d2;
            {ie, bnd, wd, exp_start, stall, d1, d2} = TBL[i];
            irq_enable = ie; insn_boundary = bnd; irq_req = 1;
            cnt = 0;
            while (!bus_req && cnt < 8) begin
                @(negedge clk);
                cnt++;
                if (!exp_start)
                    check(ie ? "R4 no start off boundary" : "R3 masked request ignored",
                          {bus_req, busy, vector_valid}, 0);
            end
            if (exp_start) begin
                check("R2 start latency", cnt, 3);
                check("R2/R5 first cycle flagged", ack_second, 0);
                insn_boundary = 0;
                if (wd) irq_req = 0;
                finish_cycle(stall, d1);
                check("R5 gap clock", bus_req, 0);
                @(negedge clk);
                check(wd ? "R8 second cycle after withdraw" : "R5 second cycle",
                      {bus_req, ack_second}, 2'b11);
                irq_req = 0;
                finish_cycle(stall, d2);
                check("R6 vector from second completion", {vector_valid, vector}, {1'b1, d2[7:0]});
                @(negedge clk);
                check("R7 valid one clock", vector_valid, 0);
                check("R5 no third cycle", bus_req, 0);
                idle_wait(4);
            end else begin
                irq_req = 0;
                idle_wait(4);
            end
            insn_boundary = 0; irq_enable = 0;
        end

        // R4: request synced while off boundary, then boundary arrives
        irq_enable = 1; irq_req = 1; insn_boundary = 0;
        repeat (5) @(negedge clk);
        check("R4 held off boundary", bus_req, 0);
        insn_boundary = 1;
        @(negedge clk);
        check("R4 start one clock after boundary", {bus_req, ack_second}, 2'b10);
        insn_boundary = 0; irq_req = 0;

        // R10: reset in the gap between cycles
        finish_cycle(1, 32'h77);
        check("R10 in gap before reset", bus_req, 0);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R10 idle after reset", {bus_req, busy, vector_valid}, 0);
        idle_wait(5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule